// File: doc/BRIEF.md
# Resonant Sustain Switch Sequencer

This block generates the gate enables for an energy-recovery sustain stage that drives two panel electrodes, called Y and X here. A sustain pulse on one electrode takes four switch phases in a fixed order: a resonant rise through the recovery inductor, a clamp to the sustain rail, a resonant fall back into the recovery capacitor, and a clamp to ground. While one electrode pulses, the other electrode is held at ground. The two electrodes take turns, so each pulse pair is one Y pulse followed by one X pulse.

A start strobe launches a burst of a requested number of pulse pairs. The length of each phase, and of the dead gap that separates switching one transistor off from switching the next one on, is given in clock cycles on input buses. These lengths are captured when the burst starts. When the burst ends, both electrodes rest in the ground phase and a one-cycle done pulse is issued. An output interlock stage checks the gate pattern on every cycle. If any electrode would have two high-side switches on at once, or a high-side switch together with its ground switch, it substitutes the safe pattern in which only the two ground switches are on.

Top module: `sustain_seq`

## Requirements
- R1: Out of reset and while idle, only `y_gnd` and `x_gnd` are 1, the six other gate enables are 0, and `done` is 0.
- R2: When `start` is sampled high while idle with `pair_cnt` nonzero, a Y pulse begins in the next cycle. Y steps through dead, rise (`y_rise`), dead, hold (`y_hold`), dead, fall (`y_fall`), dead, ground (`y_gnd`), and `x_gnd` stays 1 for the whole Y pulse.
- R3: Each Y pulse is followed at once by an X pulse with the same phase order on `x_rise`, `x_hold`, `x_fall`, `x_gnd`, and `y_gnd` stays 1 for the whole X pulse.
- R4: The rise, hold, fall and ground phases last `t_rise`, `t_hold`, `t_fall` and `t_gnd` cycles. A value of 0 on any duration input is treated as 1.
- R5: Each dead phase lasts `t_dead` cycles, with a minimum of 1. During a dead phase all four gates of the pulsing electrode are 0, so a switch always turns off at least one cycle before the next switch on that electrode turns on.
- R6: A burst contains exactly `pair_cnt` Y/X pulse pairs, back to back, with Y first in every pair.
- R7: In the cycle after the last X ground phase ends, `done` is 1 for exactly one cycle and the gates show the idle pattern of R1.
- R8: `start` with `pair_cnt` equal to 0 produces `done` in the next cycle and no change on any gate enable.
- R9: While a burst runs, `start` is ignored and changes on `pair_cnt` and the duration inputs have no effect on the burst.
- R10: On each electrode, at most one of rise, hold and fall is 1 at any time, and a high-side gate is never 1 together with that electrode's ground gate. An illegal decoded pattern is replaced by the idle pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst launch strobe, sampled while idle |
| pair_cnt | input | CNT_W | Number of Y/X pulse pairs in the burst |
| t_rise | input | DUR_W | Resonant rise length in cycles |
| t_hold | input | DUR_W | Sustain-rail clamp length in cycles |
| t_fall | input | DUR_W | Resonant fall length in cycles |
| t_gnd | input | DUR_W | Ground clamp length in cycles |
| t_dead | input | DUR_W | Dead gap length in cycles |
| y_rise | output | 1 | Y resonant rise switch enable |
| y_hold | output | 1 | Y sustain-rail switch enable |
| y_fall | output | 1 | Y resonant fall switch enable |
| y_gnd | output | 1 | Y ground switch enable |
| x_rise | output | 1 | X resonant rise switch enable |
| x_hold | output | 1 | X sustain-rail switch enable |
| x_fall | output | 1 | X resonant fall switch enable |
| x_gnd | output | 1 | X ground switch enable |
| done | output | 1 | One-cycle burst-complete pulse |

## Verification
The gate enables are decoded from registered state, so the first dead cycle of a burst shows one cycle after the edge that samples `start`. From then on the pattern advances one cycle per cycle of programmed length. With D the effective dead length and R, H, F, G the effective phase lengths, a pulse lasts P = 4D+R+H+F+G cycles, and `done` comes 2·N·P cycles after that first cycle. The bench drives and samples on the falling edge and indexes every sample by its offset from the start edge. It compares the whole 8-bit gate pattern at every offset against a model that is computed only from these segment lengths. It then checks `done` at offset 2·N·P and again one cycle later.

// File: rtl/sus_pkg.sv
package sus_pkg;

    parameter int DUR_W = 8;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_DEAD_R,
        PH_RISE,
        PH_DEAD_H,
        PH_HOLD,
        PH_DEAD_F,
        PH_FALL,
        PH_DEAD_G,
        PH_GND
    } phase_e;

    typedef enum logic {
        SIDE_Y = 1'b0,
        SIDE_X = 1'b1
    } side_e;

    typedef struct packed {
        phase_e phase;
        side_e  side;
    } seq_state_t;

    typedef struct packed {
        logic [DUR_W-1:0] rise;
        logic [DUR_W-1:0] hold;
        logic [DUR_W-1:0] fall;
        logic [DUR_W-1:0] gnd;
        logic [DUR_W-1:0] dead;
    } dur_cfg_t;

    // gate bundle of one electrode: bit 0 rise, 1 hold, 2 fall, 3 ground
    typedef struct packed {
        logic gnd;
        logic fall;
        logic hold;
        logic rise;
    } gate_set_t;

    localparam gate_set_t GATES_OFF  = '{gnd: 1'b0, fall: 1'b0, hold: 1'b0, rise: 1'b0};
    localparam gate_set_t GATES_SAFE = '{gnd: 1'b1, fall: 1'b0, hold: 1'b0, rise: 1'b0};

    function automatic logic [DUR_W-1:0] floor_one(input logic [DUR_W-1:0] v);
        return (v == '0) ? DUR_W'(1) : v;
    endfunction

    function automatic logic [DUR_W-1:0] phase_len(input phase_e p, input dur_cfg_t c);
        case (p)
            PH_RISE: return floor_one(c.rise);
            PH_HOLD: return floor_one(c.hold);
            PH_FALL: return floor_one(c.fall);
            PH_GND:  return floor_one(c.gnd);
            default: return floor_one(c.dead);
        endcase
    endfunction

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_DEAD_R: return PH_RISE;
            PH_RISE:   return PH_DEAD_H;
            PH_DEAD_H: return PH_HOLD;
            PH_HOLD:   return PH_DEAD_F;
            PH_DEAD_F: return PH_FALL;
            PH_FALL:   return PH_DEAD_G;
            PH_DEAD_G: return PH_GND;
            default:   return PH_IDLE;
        endcase
    endfunction

    function automatic logic gate_set_illegal(input gate_set_t g);
        logic [1:0] hi_cnt;
        hi_cnt = 2'(g.rise) + 2'(g.hold) + 2'(g.fall);
        return (hi_cnt > 2'd1) || ((g.rise | g.hold | g.fall) & g.gnd);
    endfunction

endpackage

// File: rtl/sus_sequencer.sv
module sus_sequencer
    import sus_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] pair_cnt,
    input  dur_cfg_t         cfg_in,
    output seq_state_t       st,
    output logic             done
);

    dur_cfg_t         cfg_q;
    logic [DUR_W-1:0] timer_q;
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.phase <= PH_IDLE;
            st.side  <= SIDE_Y;
            cfg_q    <= '0;
            timer_q  <= '0;
            left_q   <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st.phase == PH_IDLE) begin
                if (start) begin
                    if (pair_cnt == '0) begin
                        done <= 1'b1;
                    end else begin
                        cfg_q    <= cfg_in;
                        left_q   <= pair_cnt;
                        st.phase <= PH_DEAD_R;
                        st.side  <= SIDE_Y;
                        timer_q  <= floor_one(cfg_in.dead) - DUR_W'(1);
                    end
                end
            end else if (timer_q != '0) begin
                timer_q <= timer_q - DUR_W'(1);
            end else if (st.phase == PH_GND) begin
                if (st.side == SIDE_Y) begin
                    st.side  <= SIDE_X;
                    st.phase <= PH_DEAD_R;
                    timer_q  <= phase_len(PH_DEAD_R, cfg_q) - DUR_W'(1);
                end else if (left_q == CNT_W'(1)) begin
                    st.phase <= PH_IDLE;
                    st.side  <= SIDE_Y;
                    left_q   <= '0;
                    done     <= 1'b1;
                end else begin
                    left_q   <= left_q - CNT_W'(1);
                    st.side  <= SIDE_Y;
                    st.phase <= PH_DEAD_R;
                    timer_q  <= phase_len(PH_DEAD_R, cfg_q) - DUR_W'(1);
                end
            end else begin
                st.phase <= next_phase(st.phase);
                timer_q  <= phase_len(next_phase(st.phase), cfg_q) - DUR_W'(1);
            end
        end
    end

    // R7: completion pulse is a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: empty request finishes at once and stays idle
    a_r8_empty_request: assert property (@(posedge clk) disable iff (rst)
        (st.phase == PH_IDLE && start && pair_cnt == '0) |=> (done && st.phase == PH_IDLE));

    // R9: a running burst keeps its captured durations
    a_r9_cfg_held: assert property (@(posedge clk) disable iff (rst)
        (st.phase != PH_IDLE) |=> $stable(cfg_q));

endmodule

// File: rtl/sus_gate_decode.sv
module sus_gate_decode
    import sus_pkg::*;
(
    input  seq_state_t      st,
    output gate_set_t [1:0] gates
);

    for (genvar s = 0; s < 2; s++) begin : g_side
        always_comb begin
            gates[s] = GATES_SAFE;
            if (st.phase != PH_IDLE && st.side == side_e'(s)) begin
                gates[s] = GATES_OFF;
                case (st.phase)
                    PH_RISE: gates[s].rise = 1'b1;
                    PH_HOLD: gates[s].hold = 1'b1;
                    PH_FALL: gates[s].fall = 1'b1;
                    PH_GND:  gates[s].gnd  = 1'b1;
                    default: gates[s] = GATES_OFF;
                endcase
            end
        end
    end

endmodule

// File: rtl/sus_interlock.sv
module sus_interlock
    import sus_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  gate_set_t [1:0] gates_in,
    output gate_set_t [1:0] gates_out
);

    logic [1:0] bad;

    for (genvar s = 0; s < 2; s++) begin : g_chk
        assign bad[s] = gate_set_illegal(gates_in[s]);
    end

    always_comb begin
        if (|bad) begin
            gates_out[0] = GATES_SAFE;
            gates_out[1] = GATES_SAFE;
        end else begin
            gates_out = gates_in;
        end
    end

    // R10: at most one high-side switch per electrode
    a_r10_y_high_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gates_out[0].rise, gates_out[0].hold, gates_out[0].fall}));
    a_r10_x_high_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gates_out[1].rise, gates_out[1].hold, gates_out[1].fall}));
    // R10: high side and ground never together
    a_r10_no_shoot: assert property (@(posedge clk) disable iff (rst)
        !((gates_out[0].rise | gates_out[0].hold | gates_out[0].fall) & gates_out[0].gnd) &&
        !((gates_out[1].rise | gates_out[1].hold | gates_out[1].fall) & gates_out[1].gnd));

endmodule

// File: rtl/sustain_seq.sv
module sustain_seq
    import sus_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] pair_cnt,
    input  logic [DUR_W-1:0] t_rise,
    input  logic [DUR_W-1:0] t_hold,
    input  logic [DUR_W-1:0] t_fall,
    input  logic [DUR_W-1:0] t_gnd,
    input  logic [DUR_W-1:0] t_dead,
    output logic             y_rise,
    output logic             y_hold,
    output logic             y_fall,
    output logic             y_gnd,
    output logic             x_rise,
    output logic             x_hold,
    output logic             x_fall,
    output logic             x_gnd,
    output logic             done
);

    dur_cfg_t        cfg_in;
    seq_state_t      st;
    gate_set_t [1:0] raw_gates;
    gate_set_t [1:0] safe_gates;

    assign cfg_in = '{rise: t_rise, hold: t_hold, fall: t_fall, gnd: t_gnd, dead: t_dead};

    sus_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .pair_cnt (pair_cnt),
        .cfg_in   (cfg_in),
        .st       (st),
        .done     (done)
    );

    sus_gate_decode u_dec (
        .st    (st),
        .gates (raw_gates)
    );

    sus_interlock u_lock (
        .clk       (clk),
        .rst       (rst),
        .gates_in  (raw_gates),
        .gates_out (safe_gates)
    );

    assign y_rise = safe_gates[SIDE_Y].rise;
    assign y_hold = safe_gates[SIDE_Y].hold;
    assign y_fall = safe_gates[SIDE_Y].fall;
    assign y_gnd  = safe_gates[SIDE_Y].gnd;
    assign x_rise = safe_gates[SIDE_X].rise;
    assign x_hold = safe_gates[SIDE_X].hold;
    assign x_fall = safe_gates[SIDE_X].fall;
    assign x_gnd  = safe_gates[SIDE_X].gnd;

    // R2: X stays grounded while Y drives a high-side switch
    a_r2_x_grounded: assert property (@(posedge clk) disable iff (rst)
        (y_rise | y_hold | y_fall) |-> x_gnd);
    // R3: Y stays grounded while X drives a high-side switch
    a_r3_y_grounded: assert property (@(posedge clk) disable iff (rst)
        (x_rise | x_hold | x_fall) |-> y_gnd);
    // R5: a rise is always preceded by a cycle with that electrode fully off
    a_r5_y_dead_before_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(y_rise) |-> $past(!y_gnd && !y_hold && !y_fall));
    a_r5_x_dead_before_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(x_rise) |-> $past(!x_gnd && !x_hold && !x_fall));

endmodule

// File: tb/sustain_seq_tb.sv
module sustain_seq_tb;

    localparam int DW = 8;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] pair_cnt = '0;
    logic [DW-1:0] t_rise = '0, t_hold = '0, t_fall = '0, t_gnd = '0, t_dead = '0;
    logic          y_rise, y_hold, y_fall, y_gnd, x_rise, x_hold, x_fall, x_gnd, done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sustain_seq #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .pair_cnt(pair_cnt),
        .t_rise(t_rise), .t_hold(t_hold), .t_fall(t_fall), .t_gnd(t_gnd), .t_dead(t_dead),
        .y_rise(y_rise), .y_hold(y_hold), .y_fall(y_fall), .y_gnd(y_gnd),
        .x_rise(x_rise), .x_hold(x_hold), .x_fall(x_fall), .x_gnd(x_gnd),
        .done(done)
    );

    function automatic logic [7:0] observed();
        return {x_gnd, x_fall, x_hold, x_rise, y_gnd, y_fall, y_hold, y_rise};
    endfunction

    localparam logic [7:0] IDLE_PAT = 8'b1000_1000;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // expected gate pattern at offset j of a burst (lengths already floored to 1)
    function automatic logic [7:0] model(input int j, input int d, input int r,
                                         input int h, input int f, input int g);
        int p, t, u;
        logic [3:0] act;
        p = 4*d + r + h + f + g;
        t = j % (2*p);
        u = t % p;
        if (u < d)                         act = 4'b0000;
        else if (u < d+r)                  act = 4'b0001;
        else if (u < 2*d+r)                act = 4'b0000;
        else if (u < 2*d+r+h)              act = 4'b0010;
        else if (u < 3*d+r+h)              act = 4'b0000;
        else if (u < 3*d+r+h+f)            act = 4'b0100;
        else if (u < 4*d+r+h+f)            act = 4'b0000;
        else                               act = 4'b1000;
        return (t < p) ? {4'b1000, act} : {act, 4'b1000};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // launch a burst and compare every cycle against the model
    task automatic run_burst(input string req, input int n, input int d, input int r,
                             input int h, input int f, input int g, input bit disturb);
        int p, total;
        @(negedge clk);
        pair_cnt = CW'(n);
        t_dead = DW'(d); t_rise = DW'(r); t_hold = DW'(h); t_fall = DW'(f); t_gnd = DW'(g);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        p = 4*eff(d) + eff(r) + eff(h) + eff(f) + eff(g);
        total = 2*n*p;
        for (int j = 0; j < total; j++) begin
            check(req, observed(), model(j, eff(d), eff(r), eff(h), eff(f), eff(g)));
            check({req, " done low"}, {7'b0, done}, 8'h00);
            if (disturb && j == 3) begin
                // R9: new start and new settings mid-burst
                start = 1'b1;
                pair_cnt = CW'(7);
                t_dead = DW'(9); t_rise = DW'(9); t_hold = DW'(9); t_fall = DW'(9); t_gnd = DW'(9);
            end
            if (disturb && j == 4) start = 1'b0;
            @(negedge clk);
        end
        check({req, " R7 done pulse"}, {7'b0, done}, 8'h01);
        check({req, " R7 idle gates"}, observed(), IDLE_PAT);
        @(negedge clk);
        check({req, " R7 done single"}, {7'b0, done}, 8'h00);
        check({req, " R1 idle after burst"}, observed(), IDLE_PAT);
    endtask

    task automatic t_reset();
        check("R1 reset gates", observed(), IDLE_PAT);
        check("R1 reset done", {7'b0, done}, 8'h00);
    endtask

    task automatic t_empty();
        @(negedge clk);
        pair_cnt = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 empty done", {7'b0, done}, 8'h01);
        check("R8 empty gates", observed(), IDLE_PAT);
        @(negedge clk);
        check("R8 empty done single", {7'b0, done}, 8'h00);
        check("R8 empty gates stay", observed(), IDLE_PAT);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_burst("R2 R3 single pair", 1, 1, 2, 3, 2, 1, 0);
        run_burst("R4 R6 three pairs", 3, 2, 3, 4, 3, 2, 0);
        run_burst("R4 R5 zero lengths", 2, 0, 0, 0, 0, 0, 0);
        run_burst("R5 long dead", 1, 4, 1, 2, 1, 3, 0);
        t_empty();
        run_burst("R9 busy ignores inputs", 2, 1, 2, 2, 2, 1, 1);
        repeat (2) @(negedge clk);
        check("R1 final idle", observed(), IDLE_PAT);
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule